// File: doc/BRIEF.md
# Shared Syndrome Accumulator for Match-Line Error Location

This block sits beside the match lines of a ternary lookup array and locates a corrupted entry in each group of match lines. During a check pass, the array runs a fixed series of check lookups. Each entry is built so that it matches an even number of them when it is intact and an odd number when it is corrupted. Keeping a parity bit for every line would cost one register per entry. This block instead keeps one small register for each group of lines.

On every enabled lookup, each group multiplies its match vector over GF(2) by a fixed binary matrix. The column for line j of the matrix is the binary code j+1. The product is XORed into the group's syndrome register. Intact lines match an even number of times, so their codes cancel. If a group has at most one faulty line, the register holds that line's code (line index plus one) after the last lookup, or zero when the group is clean. Values read in the middle of a pass have no meaning. The code is offset by one so that a fault on line 0 reads as a nonzero value. For this reason the syndrome field is wide enough to hold GROUP_LINES.

A pass starts with a clear. The clear can arrive together with the first lookup, which saves a cycle.

Top module: `syn_accum_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every syndrome field and every error flag is zero.
- R2: Line j of a group (j = 0 .. GROUP_LINES-1) carries the binary code j+1 in a field of SYN_W = clog2(GROUP_LINES+1) bits, so a single lookup that starts from zero and has only line j matching leaves the syndrome at j+1.
- R3: Each lookup with acc_en_i high and clear_i low XORs the XOR of the codes of all matching lines of the group into that group's syndrome. The result is visible after the same clock edge.
- R4: With acc_en_i and clear_i both low, the syndrome and flag hold their values, and match_i has no effect.
- R5: clear_i high with acc_en_i low sets every syndrome to zero at the next edge.
- R6: clear_i and acc_en_i high together load each syndrome with the product of that lookup alone, ignoring the old value.
- R7: err_o[g] is high exactly when syndrome field g is nonzero. It is updated on the same edge as the field.
- R8: Group g uses match bits [g*GROUP_LINES +: GROUP_LINES] and syndrome bits [g*SYN_W +: SYN_W]. No group's lookups change another group's outputs.
- R9: Over a pass, lines that match an even number of times leave no trace. A single line that matches an odd number of times leaves its code j+1 as the final syndrome, and this includes line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Start a new check pass (zero the syndromes) |
| acc_en_i | input | 1 | Current match vector is a check lookup result |
| match_i | input | NUM_GROUPS*GROUP_LINES | Match lines, group g in bits [g*GROUP_LINES +: GROUP_LINES] |
| syndrome_o | output | NUM_GROUPS*SYN_W | Running syndrome of each group, registered |
| err_o | output | NUM_GROUPS | Group syndrome is nonzero, registered |

## Verification
Assertions inside each group check on every cycle that the flag tracks the nonzero state of the syndrome. They also check that an idle cycle leaves the syndrome unchanged, that a lone clear zeroes it, and that a clear with a lookup loads the fresh product. Only the bench's scenarios can show the values themselves. These are the code assigned to each line, including the offset for line 0, the cancellation of lines that match an even number of times over a whole pass, and the isolation between groups.

// File: rtl/syn_accum_pkg.sv
package syn_accum_pkg;

  // Width of a syndrome field able to hold codes 1..lines
  function automatic int syn_width(input int lines);
    return $clog2(lines + 1);
  endfunction

  // Operation selected for a group register on a clock edge
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_ACC   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_LOAD  = 2'd3
  } syn_op_e;

endpackage

// File: rtl/syn_gf2_product.sv
module syn_gf2_product #(
  parameter int GROUP_LINES = 8,
  parameter int SYN_W       = 4
) (
  input  logic [GROUP_LINES-1:0] match_vec,
  output logic [SYN_W-1:0]       product
);

  // Column j of the check matrix is the binary value j+1;
  // the GF(2) product is the XOR of the columns of matching lines.
  always_comb begin
    product = '0;
    for (int j = 0; j < GROUP_LINES; j++) begin
      if (match_vec[j]) product = product ^ SYN_W'(j + 1);
    end
  end

endmodule

// File: rtl/syn_group_acc.sv
module syn_group_acc
  import syn_accum_pkg::*;
#(
  parameter int GROUP_LINES = 8,
  parameter int SYN_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  syn_op_e                op,
  input  logic [GROUP_LINES-1:0] match_vec,
  output logic [SYN_W-1:0]       syn_q,
  output logic                   err_q
);

  logic [SYN_W-1:0] prod;
  logic [SYN_W-1:0] syn_d;

  syn_gf2_product #(
    .GROUP_LINES(GROUP_LINES),
    .SYN_W      (SYN_W)
  ) prod_i (
    .match_vec(match_vec),
    .product  (prod)
  );

  always_comb begin
    unique case (op)
      OP_ACC:   syn_d = syn_q ^ prod;
      OP_CLEAR: syn_d = '0;
      OP_LOAD:  syn_d = prod;
      default:  syn_d = syn_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q <= '0;
      err_q <= 1'b0;
    end else begin
      syn_q <= syn_d;
      err_q <= |syn_d;
    end
  end

  // R7
  err_tracks_syn_chk: assert property (@(posedge clk) disable iff (rst)
    err_q == (syn_q != '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(syn_q) && $stable(err_q)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLEAR) |=> (syn_q == '0 && !err_q));

  // R6
  load_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (syn_q == $past(prod)));

  // R3
  no_match_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACC && match_vec == '0) |=> $stable(syn_q));

endmodule

// File: rtl/syn_accum_top.sv
module syn_accum_top
  import syn_accum_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int GROUP_LINES = 8,
  parameter int SYN_W       = syn_width(GROUP_LINES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clear_i,
  input  logic                              acc_en_i,
  input  logic [NUM_GROUPS*GROUP_LINES-1:0] match_i,
  output logic [NUM_GROUPS*SYN_W-1:0]       syndrome_o,
  output logic [NUM_GROUPS-1:0]             err_o
);

  syn_op_e op;

  // Shared decode of the control pair for all groups
  always_comb begin
    unique case ({clear_i, acc_en_i})
      2'b01:   op = OP_ACC;
      2'b10:   op = OP_CLEAR;
      2'b11:   op = OP_LOAD;
      default: op = OP_HOLD;
    endcase
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    syn_group_acc #(
      .GROUP_LINES(GROUP_LINES),
      .SYN_W      (SYN_W)
    ) acc_i (
      .clk      (clk),
      .rst      (rst),
      .op       (op),
      .match_vec(match_i[g*GROUP_LINES +: GROUP_LINES]),
      .syn_q    (syndrome_o[g*SYN_W +: SYN_W]),
      .err_q    (err_o[g])
    );
  end

endmodule

// File: tb/syn_accum_top_tb_top.sv
module syn_accum_top_tb_top;

  localparam int G  = 4;
  localparam int M  = 8;
  localparam int SW = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic            clear_i;
  logic            acc_en_i;
  logic [G*M-1:0]  match_i;
  logic [G*SW-1:0] syndrome_o;
  logic [G-1:0]    err_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  logic [SW-1:0] exp_syn [G];

  always #5 clk = ~clk;

  syn_accum_top #(.NUM_GROUPS(G), .GROUP_LINES(M)) dut_i (
    .clk(clk), .rst(rst), .clear_i(clear_i), .acc_en_i(acc_en_i),
    .match_i(match_i), .syndrome_o(syndrome_o), .err_o(err_o)
  );

  function automatic logic [SW-1:0] code_sum(input logic [M-1:0] v);
    logic [SW-1:0] s = '0;
    for (int j = 0; j < M; j++) if (v[j]) s = s ^ SW'(j + 1);
    return s;
  endfunction

  task automatic compare(input string req);
    for (int g = 0; g < G; g++) begin
      checks++;
      if (syndrome_o[g*SW +: SW] !== exp_syn[g] || err_o[g] !== (exp_syn[g] != 0)) begin
        failures++;
        $display("FAIL %s group %0d: syn=%0d err=%0b expected syn=%0d err=%0b", req, g,
                 syndrome_o[g*SW +: SW], err_o[g], exp_syn[g], exp_syn[g] != 0);
      end
    end
  endtask

  // Drive one cycle at negedge, update model, sample at next negedge
  task automatic step(input logic clr, input logic acc, input logic [G*M-1:0] m);
    clear_i = clr; acc_en_i = acc; match_i = m;
    @(posedge clk);
    for (int g = 0; g < G; g++) begin
      if (clr && acc)  exp_syn[g] = code_sum(m[g*M +: M]);
      else if (clr)    exp_syn[g] = '0;
      else if (acc)    exp_syn[g] = exp_syn[g] ^ code_sum(m[g*M +: M]);
    end
    @(negedge clk);
    clear_i = 0; acc_en_i = 0; match_i = '0;
  endtask

  task automatic t_reset;
    rst = 1; clear_i = 0; acc_en_i = 1; match_i = '1;
    repeat (3) @(negedge clk);
    for (int g = 0; g < G; g++) exp_syn[g] = '0;
    compare("R1 during reset");
    rst = 0; acc_en_i = 0; match_i = '0;
    @(negedge clk);
    compare("R1 after reset");
  endtask

  task automatic t_single_codes;
    for (int j = 0; j < M; j++) begin
      step(1, 0, '0);
      step(0, 1, (G*M)'(1) << j);
      checks++;
      if (syndrome_o[SW-1:0] !== SW'(j + 1)) begin
        failures++;
        $display("FAIL R2 line %0d: syn=%0d expected %0d", j, syndrome_o[SW-1:0], j + 1);
      end
    end
    compare("R2 model");
  endtask

  task automatic t_multi_xor;
    step(1, 0, '0);
    step(0, 1, 32'h0000_0016);
    compare("R3 first lookup");
    step(0, 1, 32'h0000_00C2);
    compare("R3 second lookup");
    step(0, 1, 32'hA5F0_3C81);
    compare("R3 mixed groups");
  endtask

  task automatic t_hold;
    step(0, 1, 32'h1234_5678);
    step(0, 0, 32'hFFFF_FFFF);
    compare("R4 idle ignores match");
    step(0, 0, 32'h0F0F_0F0F);
    compare("R4 idle second cycle");
  endtask

  task automatic t_clear;
    step(0, 1, 32'h8421_8421);
    step(1, 0, 32'hFFFF_FFFF);
    compare("R5 clear");
  endtask

  task automatic t_clear_load;
    step(0, 1, 32'h5555_AAAA);
    step(1, 1, 32'h0180_4002);
    compare("R6 clear with lookup");
  endtask

  task automatic t_groups;
    step(1, 0, '0);
    step(0, 1, 32'h0020_0000);
    compare("R8 only group 2");
    checks++;
    if (syndrome_o !== 16'h0600 || err_o !== 4'b0100) begin
      failures++;
      $display("FAIL R8 isolation: syn=%h err=%b expected syn=0600 err=0100", syndrome_o, err_o);
    end
  endtask

  // Full pass: every line matches an even number of times except one faulty line per group
  task automatic t_pass;
    logic [G*M-1:0] keys [4];
    keys[0] = 32'hF0F0_F0F0; keys[1] = 32'h0F0F_0F0F;
    keys[2] = 32'hF0F0_F0F0; keys[3] = 32'h0F0F_0F0F;
    step(1, 1, keys[0]);
    for (int k = 1; k < 4; k++) step(0, 1, keys[k]);
    compare("R9 clean pass");
    checks++;
    if (syndrome_o !== '0 || err_o !== '0) begin
      failures++;
      $display("FAIL R9 clean: syn=%h err=%b expected 0000 0", syndrome_o, err_o);
    end
    // faults: group0 line0, group1 line7, group2 none, group3 line3
    step(1, 1, keys[0]);
    step(0, 1, keys[1] ^ 32'h0800_0001);
    step(0, 1, keys[2] ^ 32'h0000_8000);
    step(0, 1, keys[3]);
    compare("R9 faulty pass");
    checks++;
    if (syndrome_o !== 16'h4081 || err_o !== 4'b1011) begin
      failures++;
      $display("FAIL R9 locate: syn=%h err=%b expected syn=4081 err=1011", syndrome_o, err_o);
    end
  endtask

  initial begin
    clear_i = 0; acc_en_i = 0; match_i = '0; rst = 1;
    @(negedge clk);
    t_reset;
    t_single_codes;
    t_multi_xor;
    t_hold;
    t_clear;
    t_clear_load;
    t_groups;
    t_pass;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule